// File: doc/BRIEF.md
# Two-Antenna Diversity Switch Controller

This block steers a two-way RF switch that sits between two antennas and a packet radio. While the radio is receiving with diversity turned on, the block alternates the switch between the antennas on every search tick from the demodulator. When the demodulator reports a sync header, the block stops alternating and holds the current antenna for the rest of the frame. It also records that antenna in a status bit that software can read, and it raises a one-cycle receive-start pulse.

In every other case the antenna comes from a two-bit manual control field. This covers transmit, idle, sleep, and any state where diversity is off. The switch is driven through a complementary output pair. When external switch control is turned off, both wires of the pair are held at ground so that no current leaks into the switch.

When a frame ends, the lock is released and searching starts again on both antennas. The status bit keeps the antenna of the last frame until the next sync header is found.

Top module: `ant_div_switch`

## Requirements
- R1: While `extSwitchEnable` is 1, `swDriveP` equals the active antenna and `swDriveN` is its exact inverse.
- R2: While `extSwitchEnable` is 0, `swDriveP` and `swDriveN` are both 0.
- R3: The manual field `manualSel` selects antenna 1 only for code 2. Codes 0, 1 and 3 select antenna 0. The manual antenna is the active antenna whenever the block is not in diversity receive. Diversity receive means `divEnable` is 1 and `radioMode` is 1 (receive). The other mode codes are 0 idle, 2 transmit and 3 sleep.
- R4: In transmit (`radioMode` = 2), the active antenna is the manual antenna, even if a receive lock was recorded just before.
- R5: In diversity receive without a lock, each cycle with `searchTick` high toggles the search antenna. The search antenna is the active antenna, and it is 0 after reset.
- R6: In diversity receive without a lock, `syncFound` locks the search antenna. A `searchTick` in the same cycle does not toggle it. On the next cycle, `selAntenna` shows the locked antenna and `rxStartPulse` is high for exactly that one cycle. `syncFound` has no effect while a lock is held or outside diversity receive.
- R7: A lock is released by `frameDone` or by leaving diversity receive. Searching then resumes from the locked antenna. `selAntenna` does not change except at a new lock.
- R8: After reset, `selAntenna` is 0, `rxStartPulse` is 0, no lock is held and the search antenna is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divEnable | input | 1 | Diversity search enable |
| extSwitchEnable | input | 1 | Enables driving the external switch pair |
| manualSel | input | 2 | Manual antenna code |
| radioMode | input | 2 | Radio state: 0 idle, 1 receive, 2 transmit, 3 sleep |
| searchTick | input | 1 | Search-step tick from the demodulator |
| syncFound | input | 1 | Sync header found strobe |
| frameDone | input | 1 | Frame end strobe |
| swDriveP | output | 1 | Switch drive, true side |
| swDriveN | output | 1 | Switch drive, inverted side |
| selAntenna | output | 1 | Antenna recorded at the last lock |
| rxStartPulse | output | 1 | One-cycle pulse when the recorded antenna becomes valid |

## Verification
The assertions assume that the inputs are synchronous to `clk` and stable across each rising edge. They also assume that `radioMode` holds one of its four codes. Strobes may arrive in any cycle and in any combination, including `syncFound` together with `searchTick` and repeated `syncFound` during a lock. The stimulus changes inputs only just after a rising edge. It combines directed sequences for each requirement with a long random phase that draws all inputs freely from their legal ranges, so colliding strobes and mode changes in the middle of a lock are all covered.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_RX    = 2'd1,
    MODE_TX    = 2'd2,
    MODE_SLEEP = 2'd3
  } radio_mode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic useSearch;    // search antenna owns the switch this cycle
    logic stepSearch;   // toggle the search antenna
    logic captureLock;  // record the search antenna as the locked choice
  } div_strobe_t;

endpackage

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl
  import ant_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        divEnable,
  input  logic [1:0]  radioMode,
  input  logic        searchTick,
  input  logic        syncFound,
  input  logic        frameDone,
  output div_strobe_t strobe
);

  logic lockQ;
  logic lockNext;
  logic rxActive;

  assign rxActive = divEnable && (radio_mode_e'(radioMode) == MODE_RX);

  always_comb begin
    if (!rxActive)  lockNext = 1'b0;
    else if (lockQ) lockNext = !frameDone;
    else            lockNext = syncFound;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else       lockQ <= lockNext;
  end

  always_comb begin
    strobe.useSearch   = rxActive;
    strobe.captureLock = rxActive && !lockQ && syncFound;
    strobe.stepSearch  = rxActive && !lockQ && !syncFound && searchTick;
  end

  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !rxActive |=> !lockQ); // R7

  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && rxActive && !frameDone) |=> lockQ); // R6

  AST_NO_STEP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.captureLock) && rxActive && !frameDone |-> !strobe.stepSearch); // R6

endmodule

// File: rtl/ant_div_datapath.sv
module ant_div_datapath
  import ant_div_pkg::*;
#(
  parameter int CTRL_W    = 2,
  parameter int ANT1_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  div_strobe_t       strobe,
  input  logic              extSwitchEnable,
  input  logic [CTRL_W-1:0] manualSel,
  output logic              swDriveP,
  output logic              swDriveN,
  output logic              selAntenna,
  output logic              rxStartPulse
);

  localparam logic [CTRL_W-1:0] ANT1_SEL = CTRL_W'(ANT1_CODE);

  logic searchAntQ;
  logic statusAntQ;
  logic rxStartQ;
  logic manualAnt;
  logic activeAnt;

  assign manualAnt = (manualSel == ANT1_SEL);
  assign activeAnt = strobe.useSearch ? searchAntQ : manualAnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      searchAntQ <= 1'b0;
      statusAntQ <= 1'b0;
      rxStartQ   <= 1'b0;
    end else begin
      rxStartQ <= strobe.captureLock;
      if (strobe.stepSearch)  searchAntQ <= !searchAntQ;
      if (strobe.captureLock) statusAntQ <= searchAntQ;
    end
  end

  assign swDriveP     = extSwitchEnable & activeAnt;
  assign swDriveN     = extSwitchEnable & ~activeAnt;
  assign selAntenna   = statusAntQ;
  assign rxStartPulse = rxStartQ;

  AST_DRIVE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    extSwitchEnable |-> (swDriveP != swDriveN)); // R1

  AST_DRIVE_GROUNDED: assert property (@(posedge clk) disable iff (!rstN)
    !extSwitchEnable |-> (!swDriveP && !swDriveN)); // R2

  AST_SEARCH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepSearch |=> (searchAntQ != $past(searchAntQ))); // R5

  AST_RXSTART_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureLock |=> (rxStartQ && statusAntQ == $past(searchAntQ))); // R6

  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureLock |=> $stable(statusAntQ)); // R7

endmodule

// File: rtl/ant_div_switch.sv
module ant_div_switch
  import ant_div_pkg::*;
#(
  parameter int CTRL_W    = 2,
  parameter int ANT1_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divEnable,
  input  logic              extSwitchEnable,
  input  logic [CTRL_W-1:0] manualSel,
  input  logic [1:0]        radioMode,
  input  logic              searchTick,
  input  logic              syncFound,
  input  logic              frameDone,
  output logic              swDriveP,
  output logic              swDriveN,
  output logic              selAntenna,
  output logic              rxStartPulse
);

  div_strobe_t strobe;

  ant_div_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .divEnable  (divEnable),
    .radioMode  (radioMode),
    .searchTick (searchTick),
    .syncFound  (syncFound),
    .frameDone  (frameDone),
    .strobe     (strobe)
  );

  ant_div_datapath #(
    .CTRL_W    (CTRL_W),
    .ANT1_CODE (ANT1_CODE)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .extSwitchEnable (extSwitchEnable),
    .manualSel       (manualSel),
    .swDriveP        (swDriveP),
    .swDriveN        (swDriveN),
    .selAntenna      (selAntenna),
    .rxStartPulse    (rxStartPulse)
  );

  AST_TX_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    (extSwitchEnable && radioMode == 2'd2) |-> (swDriveP == (manualSel == CTRL_W'(ANT1_CODE)))); // R4

endmodule

// File: tb/sim_ant_div_switch.sv
module sim_ant_div_switch;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic divEnable = 1'b0;
  logic extSwitchEnable = 1'b0;
  logic [1:0] manualSel = 2'd0;
  logic [1:0] radioMode = 2'd0;
  logic searchTick = 1'b0;
  logic syncFound = 1'b0;
  logic frameDone = 1'b0;
  logic swDriveP, swDriveN, selAntenna, rxStartPulse;

  always #4 clk = ~clk;  // 125 MHz

  ant_div_switch u0 (
    .clk(clk), .rstN(rstN), .divEnable(divEnable), .extSwitchEnable(extSwitchEnable),
    .manualSel(manualSel), .radioMode(radioMode), .searchTick(searchTick),
    .syncFound(syncFound), .frameDone(frameDone), .swDriveP(swDriveP),
    .swDriveN(swDriveN), .selAntenna(selAntenna), .rxStartPulse(rxStartPulse)
  );

  int checks = 0;
  int fails = 0;
  string curReq = "R8";
  bit done = 1'b0;

  // behavioural reference
  int mSearch = 0;
  int mLock = 0;
  int mStat = 0;
  int mRx = 0;

  function automatic int modelAnt();
    if (divEnable && radioMode == 2'd1) return mSearch;
    return (manualSel == 2'd2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSearch = 0; mLock = 0; mStat = 0; mRx = 0;
    end else if (!(divEnable && radioMode == 2'd1)) begin
      mLock = 0; mRx = 0;
    end else if (mLock != 0) begin
      if (frameDone) mLock = 0;
      mRx = 0;
    end else if (syncFound) begin
      mLock = 1; mStat = mSearch; mRx = 1;
    end else begin
      mRx = 0;
      if (searchTick) mSearch = 1 - mSearch;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      int a;
      a = modelAnt();
      chk("swDriveP", int'(swDriveP), extSwitchEnable ? a : 0);
      chk("swDriveN", int'(swDriveN), extSwitchEnable ? 1 - a : 0);
      chk("selAntenna", int'(selAntenna), mStat);
      chk("rxStartPulse", int'(rxStartPulse), mRx);
    end
  end

  task automatic nxt();
    @(posedge clk); #1;
    searchTick = 1'b0; syncFound = 1'b0; frameDone = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      nxt(); searchTick = 1'b1;
    end
    nxt();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    curReq = "R8";
    chk("reset selAntenna", int'(selAntenna), 0);
    chk("reset rxStartPulse", int'(rxStartPulse), 0);
    nxt();

    // R2: grounded pair while searching
    curReq = "R2";
    divEnable = 1; radioMode = 2'd1; extSwitchEnable = 0;
    ticks(3);

    // R3 with R1: manual codes in idle, switch enabled
    curReq = "R3";
    divEnable = 0; radioMode = 2'd0; extSwitchEnable = 1;
    for (int c = 0; c < 4; c++) begin
      manualSel = 2'(c); nxt(); nxt();
    end
    curReq = "R1";
    divEnable = 0; radioMode = 2'd1; manualSel = 2'd2; nxt(); nxt();
    radioMode = 2'd3; manualSel = 2'd1; nxt(); nxt();

    // R5: search toggling
    curReq = "R5";
    divEnable = 1; radioMode = 2'd1; manualSel = 2'd0;
    ticks(5);

    // R6: lock with a simultaneous tick, then ignored ticks and sync
    curReq = "R6";
    nxt(); syncFound = 1; searchTick = 1;
    nxt();
    ticks(4);
    nxt(); syncFound = 1; nxt();

    // R4: transmit uses manual code
    curReq = "R4";
    radioMode = 2'd2; manualSel = 2'd2; nxt(); nxt();
    manualSel = 2'd3; nxt(); nxt();

    // R7: release by frame end, search resumes, status frozen
    curReq = "R7";
    radioMode = 2'd1;
    ticks(1);
    nxt(); syncFound = 1; nxt();
    nxt(); frameDone = 1; searchTick = 1; nxt();
    ticks(3);
    nxt(); syncFound = 1; nxt();
    divEnable = 0; nxt(); divEnable = 1; ticks(2);

    // random mix
    curReq = "R6";
    for (int i = 0; i < 4000; i++) begin
      nxt();
      extSwitchEnable = ($urandom_range(0, 9) != 0);
      divEnable       = ($urandom_range(0, 7) != 0);
      radioMode       = ($urandom_range(0, 3) != 0) ? 2'd1 : 2'($urandom_range(0, 3));
      manualSel       = 2'($urandom_range(0, 3));
      searchTick      = ($urandom_range(0, 2) == 0);
      syncFound       = ($urandom_range(0, 9) == 0);
      frameDone       = ($urandom_range(0, 11) == 0);
    end
    nxt(); nxt();
    finishRun();
  end

endmodule